// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block derives the timing references a serial transmitter and receiver need from the peripheral clock. A 16-bit integer divisor sets the base sample period in clock cycles. A fractional prescaler, set by a 4-bit add value and a 4-bit multiply field, lengthens some sample periods by one extra divisor period. Over time this gives a mean sample period of `divisor * (1 + add / (mul_field + 1))` cycles. The block outputs a one-cycle `sample_tick` per oversample and a `bit_strobe` once per bit. A mode bit picks 16 or 8 samples per bit.

Software sets it up through a byte-wide write port with four addresses: divisor low byte (0), divisor high byte (1), fraction (2: add in bits 3:0, multiply field in bits 7:4) and mode (3: bit 0 selects 8x oversampling, bit 7 unlocks the divisor bytes). The two divisor addresses are shared with other registers of the serial unit, so they are only written while the unlock bit is set. Each accepted divisor byte write restarts the timing phase. A `bit_sync` pulse from the receiver restarts it too, so the receiver can realign on a start edge.

The divider is a state machine with three states. `S_IDLE` is entered when the divisor is zero. `S_COUNT` counts one divisor period. `S_STRETCH` counts the one extra divisor period that a fractional wrap adds. Transitions:
- IDLE to COUNT when the divisor is non-zero or a restart occurs.
- COUNT to STRETCH at period end when the phase accumulator wraps.
- STRETCH to COUNT at period end.
- COUNT or STRETCH to IDLE when the divisor is zero.
- Any state to COUNT on a restart.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset the divisor is 0, and neither `sample_tick` nor `bit_strobe` is asserted.
- R2: Writes to address 0 (low byte) and address 1 (high byte) change the divisor only while mode bit 7 is 1; otherwise they are ignored and the tick phase runs on undisturbed.
- R3: With the fractional stage inactive and divisor D > 0, `sample_tick` is a one-cycle pulse every D cycles. Two ticks are never adjacent when D > 1.
- R4: With add A (fraction bits 3:0) and M = fraction bits 7:4 plus one, where 0 < A < M, the k-th tick after a restart comes D*(k + floor(k*A/M)) cycles after the restart edge.
- R5: When A = 0 or A >= M the fractional stage is bypassed and only the integer divisor sets the rate.
- R6: A divisor of 0 produces no `sample_tick` and no `bit_strobe`.
- R7: An accepted divisor byte write clears the divisor counter, the phase accumulator and the sample counter. The first tick then comes D cycles after the write edge.
- R8: `bit_strobe` is asserted only together with `sample_tick`, on every 16th tick when mode bit 0 is 0 and on every 8th tick when it is 1.
- R9: A `bit_sync` pulse restarts the divisor, accumulator and sample phases, so the next `bit_strobe` comes after a full set of oversample ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 div low, 1 div high, 2 fraction, 3 mode) |
| wr_data | input | 8 | Register write data |
| bit_sync | input | 1 | Restart the sample and bit phase |
| sample_tick | output | 1 | One-cycle oversample tick |
| bit_strobe | output | 1 | One-cycle bit-rate strobe, coincident with a tick |

## Verification
The assertions assume that a change of divisor only happens through an accepted byte write, which restarts the counters. They also assume `bit_sync` is a single-cycle pulse that is not raised together with a divisor write. The stimulus keeps to this. It changes the fraction and mode fields before the final divisor byte write of each setting, so every timed measurement starts from a clean restart. It only pulses `bit_sync` while the divisor and fraction are held constant.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
    typedef enum logic [1:0] {
        S_IDLE    = 2'd0,
        S_COUNT   = 2'd1,
        S_STRETCH = 2'd2
    } fbg_state_e;

    localparam logic [1:0] ADDR_DIV_LO = 2'd0;
    localparam logic [1:0] ADDR_DIV_HI = 2'd1;
    localparam logic [1:0] ADDR_FRAC   = 2'd2;
    localparam logic [1:0] ADDR_MODE   = 2'd3;

    localparam int MODE_OS8_BIT    = 0;
    localparam int MODE_UNLOCK_BIT = 7;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    localparam int DIV_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_q,
    output logic [FRAC_W-1:0] add_q,
    output logic [FRAC_W-1:0] mulf_q,
    output logic              os8_q,
    output logic              unlock_q,
    output logic              div_load
);
    assign div_load = wr_en && unlock_q &&
                      (wr_addr == ADDR_DIV_LO || wr_addr == ADDR_DIV_HI);

    for (genvar b = 0; b < 2; b++) begin : g_div_byte
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                div_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && unlock_q && wr_addr == 2'(b))
                div_q[b*BYTE_W +: BYTE_W] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            add_q    <= '0;
            mulf_q   <= '0;
            os8_q    <= 1'b0;
            unlock_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_FRAC) begin
                add_q  <= wr_data[FRAC_W-1:0];
                mulf_q <= wr_data[2*FRAC_W-1:FRAC_W];
            end
            if (wr_addr == ADDR_MODE) begin
                os8_q    <= wr_data[MODE_OS8_BIT];
                unlock_q <= wr_data[MODE_UNLOCK_BIT];
            end
        end
    end
endmodule

// File: rtl/fbg_div_fsm.sv
module fbg_div_fsm
    import fbg_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [DIV_W-1:0]  divisor,
    input  logic [FRAC_W-1:0] add_val,
    input  logic [FRAC_W-1:0] mul_fld,
    output logic              sample_tick,
    output logic              in_stretch,
    output logic              frac_on
);
    localparam int SUM_W = FRAC_W + 1;

    fbg_state_e         state_q, state_d;
    logic [DIV_W-1:0]   cnt_q;
    logic [FRAC_W-1:0]  acc_q;
    logic [SUM_W-1:0]   mul_eff, sum, sum_wrapped;
    logic               at_end, wrap, div_zero;

    assign div_zero    = (divisor == '0);
    assign mul_eff     = {1'b0, mul_fld} + SUM_W'(1);
    assign frac_on     = (add_val != '0) && ({1'b0, add_val} < mul_eff);
    assign sum         = {1'b0, acc_q} + {1'b0, add_val};
    assign wrap        = frac_on && (sum >= mul_eff);
    assign sum_wrapped = sum - mul_eff;
    assign at_end      = (cnt_q == divisor - DIV_W'(1));

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (!div_zero) state_d = S_COUNT;
            S_COUNT:   if (div_zero) state_d = S_IDLE;
                       else if (at_end && wrap) state_d = S_STRETCH;
            S_STRETCH: if (div_zero) state_d = S_IDLE;
                       else if (at_end) state_d = S_COUNT;
            default:   state_d = S_IDLE;
        endcase
        if (restart) state_d = S_COUNT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // divisor counter and phase accumulator
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (restart || state_q == S_IDLE) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
            if (state_q == S_COUNT && frac_on)
                acc_q <= wrap ? sum_wrapped[FRAC_W-1:0] : sum[FRAC_W-1:0];
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // outputs
    always_comb begin
        sample_tick = 1'b0;
        in_stretch  = 1'b0;
        unique case (state_q)
            S_IDLE:    sample_tick = 1'b0;
            S_COUNT:   sample_tick = !div_zero && at_end && !wrap;
            S_STRETCH: begin
                in_stretch  = 1'b1;
                sample_tick = !div_zero && at_end;
            end
            default:   sample_tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/fbg_sample_cnt.sv
module fbg_sample_cnt #(
    parameter int OS_HI = 16,
    parameter int OS_LO = 8,
    localparam int SC_W = $clog2(OS_HI)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic os8,
    input  logic tick,
    output logic strobe
);
    logic [SC_W-1:0] scnt_q;
    logic [SC_W-1:0] last;

    assign last   = os8 ? SC_W'(OS_LO - 1) : SC_W'(OS_HI - 1);
    assign strobe = tick && (scnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       scnt_q <= '0;
        else if (restart) scnt_q <= '0;
        else if (tick)    scnt_q <= strobe ? '0 : scnt_q + SC_W'(1);
    end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
    parameter int BYTE_W = 8,
    parameter int FRAC_W = 4,
    parameter int OS_HI  = 16,
    parameter int OS_LO  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              bit_sync,
    output logic              sample_tick,
    output logic              bit_strobe
);
    localparam int DIV_W = 2 * BYTE_W;

    logic [DIV_W-1:0]  div_q;
    logic [FRAC_W-1:0] add_q, mulf_q;
    logic              os8_q, unlock_q, div_load, restart;
    logic              in_stretch, frac_on;

    assign restart = div_load || bit_sync;

    fbg_regs #(.BYTE_W(BYTE_W), .FRAC_W(FRAC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_q(div_q), .add_q(add_q), .mulf_q(mulf_q),
        .os8_q(os8_q), .unlock_q(unlock_q), .div_load(div_load)
    );

    fbg_div_fsm #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_div (
        .clk(clk), .rst_n(rst_n), .restart(restart), .divisor(div_q),
        .add_val(add_q), .mul_fld(mulf_q), .sample_tick(sample_tick),
        .in_stretch(in_stretch), .frac_on(frac_on)
    );

    fbg_sample_cnt #(.OS_HI(OS_HI), .OS_LO(OS_LO)) u_smp (
        .clk(clk), .rst_n(rst_n), .restart(restart), .os8(os8_q),
        .tick(sample_tick), .strobe(bit_strobe)
    );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker #(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_addr,
    input logic             unlock,
    input logic [DIV_W-1:0] divisor,
    input logic             bit_sync,
    input logic             sample_tick,
    input logic             bit_strobe,
    input logic             in_stretch,
    input logic             frac_on
);
    assert_strobe_with_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> sample_tick);

    assert_zero_div_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (divisor == '0) |-> !sample_tick);

    assert_locked_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !unlock && wr_addr[1] == 1'b0) |=> $stable(divisor));

    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && divisor > DIV_W'(1) && !wr_en) |=> !sample_tick);

    assert_sync_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bit_sync |=> !bit_strobe);

    assert_bypass_no_stretch_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_stretch) |-> $past(frac_on));
endmodule

bind frac_baud_gen fbg_checker #(.DIV_W(2 * BYTE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .unlock(unlock_q), .divisor(div_q), .bit_sync(bit_sync),
    .sample_tick(sample_tick), .bit_strobe(bit_strobe),
    .in_stretch(in_stretch), .frac_on(frac_on)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       bit_sync = 1'b0;
    logic       sample_tick, bit_strobe;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .bit_sync(bit_sync),
        .sample_tick(sample_tick), .bit_strobe(bit_strobe)
    );

    // {div_hi, div_lo, add, mul_field, os8 byte, cycle of 16th tick}
    localparam logic [47:0] VECS [7] = '{
        48'h0004_00_00_0040,
        48'h0003_11_00_0048,
        48'h0002_34_00_0032,
        48'h0005_21_00_0050,
        48'h0102_00_01_1020,
        48'h0001_1F_01_0011,
        48'h0007_56_00_00BD
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // cycle index 1 is the first negedge after the restart edge
    task automatic measure(input int k, output int cyc, output int strobes);
        int t = 0;
        cyc = 1; strobes = 0;
        while (1) begin
            if (bit_strobe) strobes++;
            if (sample_tick) t++;
            if (t >= k || cyc >= 20000) break;
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic tick_gap(output int g);
        int w = 0;
        while (!sample_tick && w < 1000) begin @(negedge clk); w++; end
        g = 0;
        do begin @(negedge clk); g++; end while (!sample_tick && g < 1000);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc, str, cnt_t, cnt_s, g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet after reset
        cnt_t = 0; cnt_s = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (sample_tick) cnt_t++;
            if (bit_strobe) cnt_s++;
        end
        check("R1 ticks after reset", cnt_t, 0);
        check("R1 strobes after reset", cnt_s, 0);

        // table walk: R3 R4 R5 R7 R8
        for (int i = 0; i < 7; i++) begin
            logic [47:0] v;
            int a, m, os8;
            v   = VECS[i];
            a   = int'(v[31:28]);
            m   = int'(v[27:24]) + 1;
            os8 = int'(v[16]);
            reg_wr(2'd3, {1'b1, 6'd0, v[16]});
            reg_wr(2'd2, {v[27:24], v[31:28]});
            reg_wr(2'd1, v[47:40]);
            reg_wr(2'd0, v[39:32]);
            measure(16, cyc, str);
            if (a == 0 || a >= m) check("R3/R5/R7 16th tick cycle", cyc, int'(v[15:0]));
            else                  check("R4/R7 16th tick cycle", cyc, int'(v[15:0]));
            check("R8 strobes by 16th tick", str, (os8 != 0) ? 2 : 1);
        end

        // R2: locked divisor bytes are ignored
        reg_wr(2'd3, 8'h80);
        reg_wr(2'd2, 8'h00);
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'h04);
        reg_wr(2'd3, 8'h00);
        reg_wr(2'd0, 8'h09);
        tick_gap(g);
        check("R2 low byte ignored while locked", g, 4);
        reg_wr(2'd1, 8'h55);
        tick_gap(g);
        check("R2 high byte ignored while locked", g, 4);

        // R7: reload mid-run
        reg_wr(2'd3, 8'h80);
        reg_wr(2'd0, 8'h06);
        measure(1, cyc, str);
        check("R7 first tick after reload", cyc, 6);

        // R9 and R8 with 8x oversampling
        reg_wr(2'd3, 8'h81);
        reg_wr(2'd0, 8'h02);
        repeat (5) @(negedge clk);
        @(negedge clk); bit_sync = 1'b1;
        @(negedge clk); bit_sync = 1'b0;
        cyc = 1;
        while (!bit_strobe && cyc < 20000) begin @(negedge clk); cyc++; end
        check("R9 first strobe after sync", cyc, 16);
        cnt_t = 0;
        do begin
            @(negedge clk);
            if (sample_tick) cnt_t++;
        end while (!bit_strobe && cnt_t < 100);
        check("R8 ticks per strobe at 8x", cnt_t, 8);

        // R6: zero divisor
        reg_wr(2'd1, 8'h00);
        reg_wr(2'd0, 8'h00);
        cnt_t = 0; cnt_s = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (sample_tick) cnt_t++;
            if (bit_strobe) cnt_s++;
        end
        check("R6 ticks with zero divisor", cnt_t, 0);
        check("R6 strobes with zero divisor", cnt_s, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule